// File: doc/BRIEF.md
# DRAM Access Cycle State Sequencer

This block steps one DRAM access, or one refresh, through its bus states. Every cycle opens with a precharge phase of one or two states. The precharge phase guarantees the RAS precharge time. An access then moves through a row state and a first column state, then through zero or more wait states, and ends in a second column state. A refresh cycle reuses the same precharge phase and ends in a single refresh state. The sequencer drives RAS, CAS, write-enable, a row/column address-select strobe and a one-cycle done flag. These are decoded from the current state, which is also brought out as a 3-bit code.

Wait states come from two sources, and both can apply in the same access. A programmed count of 0 to 3 applies when programmed waits are enabled. An active-low WAIT pin applies when pin waits are enabled. The pin is captured on the falling clock edge. It is only consulted at the last point before the second column state would begin. That point is the first column state if there are no programmed waits, and the last programmed wait state otherwise. Each low sample adds one more wait state. The configuration is captured when a request is accepted, so changes made during an access have no effect on it.

Top module: `dram_cyc_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the state code is 0 (idle) and RAS, CAS, write-enable, column-select and done are all low. Reset asserted during an access returns the state code to 0 at once.
- R2: An accepted access shows state codes in this order: 1 (first precharge), optionally 2 (second precharge), 3 (row), 4 (first column), 5 for each wait state, 6 (second column), then 0.
- R3: The precharge phase lasts one state when the two-precharge bit is 0 and two states when it is 1. This holds for both accesses and refreshes.
- R4: When programmed waits are enabled, exactly wait_cnt_i wait states (0 to 3) are placed between codes 4 and 6. When programmed waits are disabled, wait_cnt_i has no effect.
- R5: With the pin enable at 1, wait_n_i is captured on the falling clock edge. The capture is made in code 4 when there are no programmed waits, and otherwise in the last programmed wait state. A low capture adds one wait state, and the capture repeats in each added state. The pin is ignored during earlier programmed waits, and at all times when the pin enable is 0.
- R6: RAS is high in codes 3 to 7 and low in precharge and idle. CAS is high in codes 4, 5, 6 and 7. Column-select is high in codes 4, 5 and 6 only.
- R7: Write-enable is high only in codes 4, 5 and 6 of a write access, and never for a read or a refresh.
- R8: An accepted refresh shows code 1, optionally code 2, then code 7, then 0. A refresh request wins over an access request made in the same idle cycle.
- R9: Done is high only in the final state of a cycle, which is code 6 or code 7. The next state is idle, and a request held high there starts a new cycle one state later.
- R10: The write flag and all configuration inputs are captured in the idle cycle that accepts a request. Changing them during the cycle does not alter its sequence or strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; WAIT is captured on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_req_i | input | 1 | Access request, sampled in idle |
| acc_wr_i | input | 1 | 1 = write access, 0 = read |
| ref_req_i | input | 1 | Refresh request, sampled in idle, wins over acc_req_i |
| two_pre_i | input | 1 | 1 = two precharge states, 0 = one |
| pgm_wait_en_i | input | 1 | Enables programmed wait states |
| wait_cnt_i | input | 2 | Programmed wait count |
| pin_wait_en_i | input | 1 | Enables the WAIT pin |
| wait_n_i | input | 1 | Active-low WAIT pin |
| state_o | output | 3 | Current state code |
| ras_o | output | 1 | Row strobe, active high |
| cas_o | output | 1 | Column strobe, active high |
| we_o | output | 1 | Write-enable, active high |
| col_sel_o | output | 1 | 1 = column address phase, 0 = row phase |
| done_o | output | 1 | High in the final state of a cycle |

## Verification
The most error-prone point is where the WAIT pin is consulted. If the pin were consulted during every programmed wait, a low WAIT would stretch an access beyond max(programmed, pin) waits. If it were never consulted in the first column state, pin-only waits would be lost. Vectors with WAIT held low for fewer, equal and more cycles than the programmed count expose both faults. After each request is accepted, the bench inverts every configuration input. A design that reads the live inputs instead of the captured copies then shows the wrong precharge or wait count, or a wrong write-enable. Simultaneous access and refresh requests, back-to-back requests and a reset in mid-access check the priority and the return to idle.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    // State codes are visible on state_o; the values are part of the interface.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PRE1 = 3'd1,
        ST_PRE2 = 3'd2,
        ST_ROW  = 3'd3,
        ST_COL1 = 3'd4,
        ST_WAIT = 3'd5,
        ST_COL2 = 3'd6,
        ST_RFSH = 3'd7
    } seq_state_e;

endpackage

// File: rtl/dram_seq_waitctl.sv
module dram_seq_waitctl
    import dram_seq_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  seq_state_e       state_i,
    input  logic             pgm_en_i,
    input  logic [CNT_W-1:0] pgm_cnt_i,
    input  logic             pin_en_i,
    input  logic             wait_n_i,
    output logic             more_o
);

    logic [CNT_W-1:0] rem_d, rem_q;
    logic             wait_low_q;
    logic             pin_low;

    // WAIT is captured on the falling edge, half a cycle before the decision.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) wait_low_q <= 1'b0;
        else        wait_low_q <= ~wait_n_i;
    end

    always_comb begin
        pin_low = pin_en_i && wait_low_q;
        more_o  = 1'b0;
        rem_d   = rem_q;
        case (state_i)
            ST_COL1: begin
                if (pgm_en_i && (pgm_cnt_i != '0)) begin
                    more_o = 1'b1;
                    rem_d  = pgm_cnt_i - CNT_W'(1);
                end else begin
                    more_o = pin_low;
                    rem_d  = '0;
                end
            end
            ST_WAIT: begin
                if (rem_q != '0) begin
                    more_o = 1'b1;
                    rem_d  = rem_q - CNT_W'(1);
                end else begin
                    more_o = pin_low;
                    rem_d  = '0;
                end
            end
            default: begin
                more_o = 1'b0;
                rem_d  = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rem_q <= '0;
        else        rem_q <= rem_d;
    end

    // Programmed waits still pending keep the sequencer in the wait state.
    p_pgm_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_WAIT && rem_q != '0) |=> (state_i == ST_WAIT));

    // Pin disabled: the wait phase ends exactly when the programmed count is used up.
    p_pin_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_WAIT && rem_q == '0 && !pin_en_i) |=> (state_i == ST_COL2));

endmodule

// File: rtl/dram_seq_strobes.sv
module dram_seq_strobes
    import dram_seq_pkg::*;
(
    input  seq_state_e state_i,
    input  logic       wr_i,
    output logic       ras_o,
    output logic       cas_o,
    output logic       we_o,
    output logic       col_sel_o,
    output logic       done_o
);

    logic col_phase;

    always_comb begin
        col_phase = (state_i == ST_COL1) || (state_i == ST_WAIT) || (state_i == ST_COL2);
        ras_o     = col_phase || (state_i == ST_ROW) || (state_i == ST_RFSH);
        cas_o     = col_phase || (state_i == ST_RFSH);
        col_sel_o = col_phase;
        we_o      = col_phase && wr_i;
        done_o    = (state_i == ST_COL2) || (state_i == ST_RFSH);
    end

endmodule

// File: rtl/dram_cyc_seq.sv
module dram_cyc_seq
    import dram_seq_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_req_i,
    input  logic             acc_wr_i,
    input  logic             ref_req_i,
    input  logic             two_pre_i,
    input  logic             pgm_wait_en_i,
    input  logic [CNT_W-1:0] wait_cnt_i,
    input  logic             pin_wait_en_i,
    input  logic             wait_n_i,
    output logic [2:0]       state_o,
    output logic             ras_o,
    output logic             cas_o,
    output logic             we_o,
    output logic             col_sel_o,
    output logic             done_o
);

    typedef struct packed {
        seq_state_e       st;
        logic             rf;
        logic             wr;
        logic             two;
        logic             pe;
        logic [CNT_W-1:0] cnt;
        logic             pin;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic      more_wait;

    dram_seq_waitctl #(.CNT_W(CNT_W)) u_wait (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_i   (r_q.st),
        .pgm_en_i  (r_q.pe),
        .pgm_cnt_i (r_q.cnt),
        .pin_en_i  (r_q.pin),
        .wait_n_i  (wait_n_i),
        .more_o    (more_wait)
    );

    dram_seq_strobes u_strb (
        .state_i   (r_q.st),
        .wr_i      (r_q.wr),
        .ras_o     (ras_o),
        .cas_o     (cas_o),
        .we_o      (we_o),
        .col_sel_o (col_sel_o),
        .done_o    (done_o)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (ref_req_i) begin
                    r_d.st  = ST_PRE1;
                    r_d.rf  = 1'b1;
                    r_d.wr  = 1'b0;
                    r_d.two = two_pre_i;
                    r_d.pe  = 1'b0;
                    r_d.cnt = '0;
                    r_d.pin = 1'b0;
                end else if (acc_req_i) begin
                    r_d.st  = ST_PRE1;
                    r_d.rf  = 1'b0;
                    r_d.wr  = acc_wr_i;
                    r_d.two = two_pre_i;
                    r_d.pe  = pgm_wait_en_i;
                    r_d.cnt = wait_cnt_i;
                    r_d.pin = pin_wait_en_i;
                end
            end
            ST_PRE1: begin
                if (r_q.two)     r_d.st = ST_PRE2;
                else if (r_q.rf) r_d.st = ST_RFSH;
                else             r_d.st = ST_ROW;
            end
            ST_PRE2: r_d.st = r_q.rf ? ST_RFSH : ST_ROW;
            ST_ROW:  r_d.st = ST_COL1;
            ST_COL1, ST_WAIT: r_d.st = more_wait ? ST_WAIT : ST_COL2;
            ST_COL2, ST_RFSH: r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign state_o = r_q.st;

    p_row_after_pre_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ROW) |-> ($past(r_q.st) == ST_PRE1 || $past(r_q.st) == ST_PRE2));

    p_col2_after_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_COL2) |-> ($past(r_q.st) == ST_COL1 || $past(r_q.st) == ST_WAIT));

    p_cas_in_ras_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cas_o |-> ras_o);

    p_we_write_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |-> (col_sel_o && !r_q.rf));

    p_done_to_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (r_q.st == ST_IDLE));

    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE && r_q.st != ST_PRE1) |->
            ($stable(r_q.wr) && $stable(r_q.two) && $stable(r_q.pe)
             && $stable(r_q.cnt) && $stable(r_q.pin) && $stable(r_q.rf)));

endmodule

// File: tb/dram_cyc_seq_tb.sv
module dram_cyc_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_req = 1'b0, acc_wr = 1'b0, ref_req = 1'b0;
    logic       two_pre = 1'b0, pgm_en = 1'b0, pin_en = 1'b0, wait_n = 1'b1;
    logic [1:0] wcnt = 2'd0;
    logic [2:0] state;
    logic       ras, cas, we, col_sel, done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dram_cyc_seq dut_i (
        .clk(clk), .rst_n(rst_n), .acc_req_i(acc_req), .acc_wr_i(acc_wr),
        .ref_req_i(ref_req), .two_pre_i(two_pre), .pgm_wait_en_i(pgm_en),
        .wait_cnt_i(wcnt), .pin_wait_en_i(pin_en), .wait_n_i(wait_n),
        .state_o(state), .ras_o(ras), .cas_o(cas), .we_o(we),
        .col_sel_o(col_sel), .done_o(done)
    );

    // Fields: [9]=refresh [8]=write [7]=two precharge [6]=pgm enable
    //         [5:4]=wait count [3]=pin enable [2:0]=cycles WAIT low from first column state
    localparam int NVEC = 12;
    localparam logic [9:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 3'd0},
        {1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 3'd0},
        {1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 1'b0, 3'd0},
        {1'b0, 1'b1, 1'b1, 1'b1, 2'd2, 1'b0, 3'd0},
        {1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 3'd0},
        {1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 3'd2},
        {1'b0, 1'b1, 1'b0, 1'b1, 2'd1, 1'b1, 3'd3},
        {1'b0, 1'b0, 1'b1, 1'b1, 2'd3, 1'b1, 3'd2},
        {1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 3'd3},
        {1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 1'b1, 3'd2},
        {1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 3'd0},
        {1'b1, 1'b1, 1'b1, 1'b1, 2'd3, 1'b1, 3'd4}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_strobes(input int st, input bit wr);
        bit e_col = (st == 4 || st == 5 || st == 6);
        bit e_ras = (st >= 3);
        bit e_cas = (st >= 4);
        chk(ras == e_ras, "R6 ras", ras, e_ras);
        chk(cas == e_cas, "R6 cas", cas, e_cas);
        chk(col_sel == e_col, "R6 col_sel", col_sel, e_col);
        chk(we == (e_col && wr), "R7 we", we, e_col && wr);
        chk(done == (st == 6 || st == 7), "R9 done", done, st == 6 || st == 7);
    endtask

    task automatic run_vec(input logic [9:0] v);
        bit rf = v[9], wr = v[8], two = v[7], pe = v[6], pin = v[3];
        int cnt = v[5:4], lowc = v[2:0];
        int npre = two ? 2 : 1;
        int p = pe ? cnt : 0;
        int w = pin ? ((lowc > p) ? lowc : p) : p;
        int c1 = npre + 1;
        int exp_st [16];
        int len = 0;
        for (int k = 0; k < npre; k++) exp_st[len++] = k + 1;
        if (rf) exp_st[len++] = 7;
        else begin
            exp_st[len++] = 3;
            exp_st[len++] = 4;
            for (int k = 0; k < w; k++) exp_st[len++] = 5;
            exp_st[len++] = 6;
        end
        exp_st[len] = 0;
        // Request; a refresh is issued together with an access to test priority (R8).
        ref_req = rf; acc_req = 1'b1; acc_wr = wr;
        two_pre = two; pgm_en = pe; wcnt = 2'(cnt); pin_en = pin;
        @(posedge clk); #1;
        // Inverted configuration must not reach the running cycle (R10).
        ref_req = 1'b0; acc_req = 1'b0; acc_wr = ~wr;
        two_pre = ~two; pgm_en = ~pe; wcnt = ~2'(cnt); pin_en = ~pin;
        for (int i = 0; i <= len; i++) begin
            wait_n = !(!rf && i >= c1 && i < c1 + lowc);
            #3;
            chk(state == 3'(exp_st[i]),
                rf ? "R8 refresh state" : (i < npre ? "R3 precharge" :
                     (i > c1 ? (pin ? "R5 pin wait" : "R4 programmed wait") : "R2 order")),
                state, exp_st[i]);
            chk_strobes(exp_st[i], wr && !rf);
            @(posedge clk); #1;
        end
        chk(state == 3'd0, "R10 cycle length with inputs changed", state, 0);
        wait_n = 1'b1;
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        acc_req = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk(state == 3'd0, "R1 state in reset", state, 0);
        chk_strobes(0, 1'b0);
        acc_req = 1'b0;
        rst_n = 1'b1;
        #3;
        chk(state == 3'd0, "R1 state after release", state, 0);
        @(posedge clk); #1;

        foreach (VEC[i]) run_vec(VEC[i]);

        // R9: back-to-back requests, one idle state between cycles
        begin
            int seqv [6] = '{1, 3, 4, 6, 0, 1};
            acc_req = 1'b1; acc_wr = 1'b0; two_pre = 1'b0; pgm_en = 1'b0; pin_en = 1'b0;
            @(posedge clk); #1;
            for (int i = 0; i < 6; i++) begin
                #3;
                chk(state == 3'(seqv[i]), "R9 back-to-back", state, seqv[i]);
                @(posedge clk); #1;
            end
            acc_req = 1'b0;
            repeat (8) @(posedge clk);
            #1;
        end

        // R1: reset during programmed waits
        acc_req = 1'b1; pgm_en = 1'b1; wcnt = 2'd3; acc_wr = 1'b1;
        @(posedge clk); #1;
        acc_req = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        chk(state == 3'd5, "R4 in wait before reset", state, 5);
        rst_n = 1'b0;
        #2;
        chk(state == 3'd0, "R1 reset mid-access", state, 0);
        chk(we == 1'b0, "R1 we cleared", we, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule